// File: doc/BRIEF.md
# Instruction Breakpoint Comparator Bank

This block watches the instruction fetch address of a processor core and raises a breakpoint halt request when the address hits one of a small set of programmable comparators. Each comparator holds a word address inside the low 512 MiB code region and a two-bit half-word selector. The selector chooses whether the lower half-word, the upper half-word, both or neither of that word trigger. A single global enable gates the whole bank. That enable can only be changed by a write that also carries a key bit.

Software programs the bank over a simple 32-bit register bus. Writes take effect at the clock edge and reads are combinational. The map is as follows. Word 0x00 is the global control register: bit 0 is the enable, bit 1 is the write key, and bits 7:4 are a read-only comparator count. Word 0x04 is the debug event status register, whose bit 0 is a sticky breakpoint flag. Comparator i sits at 0x08 + 4*i.

A comparator register has three fields: bit 0 is the enable, bits 28:2 are the word address, and bits 31:30 are the half-word selector. All other bits are discarded on write and read back as zero. A hit produces a one-cycle request on the clock edge after the fetch, together with the index of the comparator that fired.

Top module: `ibp_bank`

## Requirements
- R1: After reset, the control register reads NUM_CMP << 4 (0x60 for the default of 6), the status register and every comparator register read 0, and no request is raised.
- R2: A comparator register keeps only bits 31:30, 28:2 and 0 of a write; bits 29 and 1 read back as zero.
- R3: A comparator matches only when fetch address bits 28:2 equal its stored word address and fetch address bits 31:29 are all zero.
- R4: A write to the control register changes the global enable (bit 0) only when bit 1 of the written data is 1; otherwise the enable keeps its value.
- R5: Control bits 7:4 always read the comparator count and are not altered by any write.
- R6: Selector 01 matches only fetch address bit 1 = 0, 10 matches only bit 1 = 1, 11 matches either, and 00 never matches.
- R7: A request is raised only when the global enable is 1, the comparator's bit 0 is 1 and fetch_valid is high with a matching address; writing a comparator with bit 0 = 0 stops it from firing.
- R8: bkpt_req is high for exactly the one cycle after each matching valid fetch cycle, and bkpt_idx gives the firing comparator's index in that cycle.
- R9: When several comparators match the same fetch, bkpt_idx gives the lowest index.
- R10: Status bit 0 is set together with every request and stays set until a status write with bit 0 = 1; a status write with bit 0 = 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (8) | Byte address of the register; bits 1:0 ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 32 | Instruction fetch byte address |
| bkpt_req | output | 1 | Breakpoint halt request pulse |
| bkpt_idx | output | IDX_W (3) | Index of the comparator that raised the request |

## Verification
The assertions assume that fetch_valid and fetch_addr are driven cleanly once per cycle and that a fetch address is meaningful only while fetch_valid is high. They also assume that register writes are single-cycle strobes with a stable address. The bench drives every input on the falling edge and holds it for a full cycle. It raises fetch_valid for exactly one cycle per fetch and writes registers only while no fetch is pending, so each request pulse can be traced back to a single fetch. The expected results come from the comparator programming the bench itself wrote.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

   localparam int unsigned MAX_CMP  = 6;
   localparam int unsigned WADDR_LO = 2;
   localparam int unsigned WADDR_HI = 28;

   typedef enum logic [1:0] {
      HSEL_NONE  = 2'b00,
      HSEL_LOWER = 2'b01,
      HSEL_UPPER = 2'b10,
      HSEL_BOTH  = 2'b11
   } hsel_e;

   typedef struct packed {
      hsel_e                      hsel;
      logic [WADDR_HI:WADDR_LO]   waddr;
      logic                       en;
   } cmp_cfg_t;

   function automatic cmp_cfg_t cfg_from_word(input logic [31:0] w);
      cmp_cfg_t c;
      c.hsel  = hsel_e'(w[31:30]);
      c.waddr = w[WADDR_HI:WADDR_LO];
      c.en    = w[0];
      return c;
   endfunction

   function automatic logic [31:0] word_from_cfg(input cmp_cfg_t c);
      logic [31:0] w;
      w = '0;
      w[31:30]              = c.hsel;
      w[WADDR_HI:WADDR_LO]  = c.waddr;
      w[0]                  = c.en;
      return w;
   endfunction

endpackage

// File: rtl/ibp_comparator.sv
module ibp_comparator
   import ibp_pkg::*;
#(
   parameter bit REGION_CHECK = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wdata,
   output logic [31:0] cfg_word,
   input  logic        fetch_valid,
   input  logic [31:0] fetch_addr,
   output logic        hit
);

   cmp_cfg_t cfg_q;
   logic     addr_eq;
   logic     region_ok;
   logic     half_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         cfg_q <= cfg_from_word(wdata);
      end
   end

   assign cfg_word = word_from_cfg(cfg_q);
   assign addr_eq  = (fetch_addr[WADDR_HI:WADDR_LO] == cfg_q.waddr);

   generate
      if (REGION_CHECK) begin : g_region
         assign region_ok = (fetch_addr[31:WADDR_HI+1] == '0);
      end else begin : g_alias
         assign region_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (cfg_q.hsel)
         HSEL_LOWER: half_ok = ~fetch_addr[1];
         HSEL_UPPER: half_ok =  fetch_addr[1];
         HSEL_BOTH:  half_ok = 1'b1;
         default:    half_ok = 1'b0;
      endcase
   end

   assign hit = fetch_valid & cfg_q.en & addr_eq & region_ok & half_ok;

   AST_CMP_CLEARED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[0]) |=> !hit);   // R7
   AST_CMP_NONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[31:30] == 2'b00) |=> !hit);   // R6

endmodule

// File: rtl/ibp_prio.sv
module ibp_prio #(
   parameter int unsigned N     = 6,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/ibp_bank.sv
module ibp_bank
   import ibp_pkg::*;
#(
   parameter int unsigned NUM_CMP      = 6,
   parameter int unsigned REG_AW       = 8,
   parameter bit          REGION_CHECK = 1'b1,
   localparam int unsigned IDX_W       = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              fetch_valid,
   input  logic [31:0]       fetch_addr,
   output logic              bkpt_req,
   output logic [IDX_W-1:0]  bkpt_idx
);

   localparam int unsigned WIDX_W    = REG_AW - 2;
   localparam int unsigned CTRL_WORD = 0;
   localparam int unsigned STAT_WORD = 1;
   localparam int unsigned CMP_WORD  = 2;
   localparam int unsigned CTRL_EN_B = 0;
   localparam int unsigned CTRL_KY_B = 1;
   localparam logic [3:0]  CMP_COUNT = 4'(NUM_CMP);

   generate
      if (NUM_CMP < 1 || NUM_CMP > MAX_CMP) begin : g_bad_count
         $error("ibp_bank: NUM_CMP out of range");
      end
      if ((2 ** REG_AW) < 4 * (CMP_WORD + NUM_CMP)) begin : g_bad_aw
         $error("ibp_bank: REG_AW too small for the register map");
      end
   endgenerate

   logic [WIDX_W-1:0]  word_idx;
   logic               ctrl_wr;
   logic               stat_wr;
   logic               glb_en_q;
   logic               flag_q;
   logic [NUM_CMP-1:0] cmp_wr;
   logic [NUM_CMP-1:0] hits;
   logic [31:0]        cmp_word [NUM_CMP];
   logic               hit_any;
   logic [IDX_W-1:0]   win_idx;

   assign word_idx = reg_addr[REG_AW-1:2];
   assign ctrl_wr  = reg_we && (word_idx == WIDX_W'(CTRL_WORD));
   assign stat_wr  = reg_we && (word_idx == WIDX_W'(STAT_WORD));

   // Global enable: only a keyed write reaches it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glb_en_q <= 1'b0;
      end else if (ctrl_wr && reg_wdata[CTRL_KY_B]) begin
         glb_en_q <= reg_wdata[CTRL_EN_B];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
         localparam logic [WIDX_W-1:0] MY_WORD = WIDX_W'(CMP_WORD + gi);
         assign cmp_wr[gi] = reg_we && (word_idx == MY_WORD);
         ibp_comparator #(
            .REGION_CHECK (REGION_CHECK)
         ) u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (cmp_wr[gi]),
            .wdata       (reg_wdata),
            .cfg_word    (cmp_word[gi]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .hit         (hits[gi])
         );
      end
   endgenerate

   ibp_prio #(
      .N     (NUM_CMP),
      .IDX_W (IDX_W)
   ) u_prio (
      .req (hits),
      .any (hit_any),
      .idx (win_idx)
   );

   // Request pulse and index, one cycle after the fetch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bkpt_req <= 1'b0;
         bkpt_idx <= '0;
      end else begin
         bkpt_req <= hit_any & glb_en_q;
         if (hit_any & glb_en_q) bkpt_idx <= win_idx;
      end
   end

   // Sticky event flag: set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit_any & glb_en_q) begin
         flag_q <= 1'b1;
      end else if (stat_wr && reg_wdata[0]) begin
         flag_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (word_idx == WIDX_W'(CTRL_WORD)) begin
         reg_rdata[7:4]       = CMP_COUNT;
         reg_rdata[CTRL_EN_B] = glb_en_q;
      end else if (word_idx == WIDX_W'(STAT_WORD)) begin
         reg_rdata[0] = flag_q;
      end else begin
         for (int i = 0; i < NUM_CMP; i++) begin
            if (word_idx == WIDX_W'(CMP_WORD + i)) reg_rdata = cmp_word[i];
         end
      end
   end

   AST_CTRL_NOKEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !reg_wdata[CTRL_KY_B]) |=> $stable(glb_en_q));   // R4
   AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_req |-> $past(glb_en_q) && $past(fetch_valid));   // R7
   AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_req |-> flag_q);   // R10
   AST_REQ_IDX_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_req |-> $past(hits[win_idx]));   // R8
   AST_WIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any |-> ((hits & ((NUM_CMP'(1) << win_idx) - NUM_CMP'(1))) == '0));   // R9
   AST_REQ_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      bkpt_req |-> $past($countones(hits) > 0));   // R8

endmodule

// File: tb/tb_ibp_bank.sv
module tb_ibp_bank;

   localparam int NUM_CMP = 6;
   localparam int REG_AW  = 8;
   localparam int IDX_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [REG_AW-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              fetch_valid = 1'b0;
   logic [31:0]       fetch_addr = '0;
   logic              bkpt_req;
   logic [IDX_W-1:0]  bkpt_idx;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   ibp_bank #(.NUM_CMP(NUM_CMP), .REG_AW(REG_AW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .bkpt_req(bkpt_req), .bkpt_idx(bkpt_idx));

   // {fetch address, expected request, expected index}
   localparam int NV = 11;
   localparam logic [35:0] VEC [NV] = '{
      {32'h0000_1000, 1'b1, 3'd0},   // R6 lower
      {32'h0000_1002, 1'b1, 3'd1},   // R6 upper
      {32'h0000_2000, 1'b1, 3'd2},   // R9 both 2 and 4, R6 both
      {32'h0000_2002, 1'b1, 3'd2},   // R6 both
      {32'h0000_3000, 1'b0, 3'd0},   // R6 selector 00
      {32'h0000_3002, 1'b0, 3'd0},   // R6 selector 00
      {32'h0000_2004, 1'b0, 3'd0},   // R3 next word
      {32'h2000_1000, 1'b0, 3'd0},   // R3 outside region
      {32'h1FFF_FFFE, 1'b1, 3'd5},   // R3 top of region
      {32'h1FFF_FFFC, 1'b1, 3'd5},   // R3
      {32'h0000_1004, 1'b0, 3'd0}    // R3
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic fetch(input string req, input logic [31:0] a,
                        input logic exp_req, input logic [IDX_W-1:0] exp_idx);
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = a;
      @(negedge clk);
      fetch_valid = 1'b0;
      check(req, 32'(bkpt_req), 32'(exp_req));
      if (exp_req) check({req, " R8 idx"}, 32'(bkpt_idx), 32'(exp_idx));
      @(negedge clk);
      check("R8 pulse ends", 32'(bkpt_req), 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, v); check("R1 ctrl", v, 32'h60);
      rd(8'h04, v); check("R1 status", v, 32'h0);
      for (int i = 0; i < NUM_CMP; i++) begin
         rd(8'(8 + 4 * i), v); check("R1 cmp", v, 32'h0);
      end
      check("R1 req", 32'(bkpt_req), 32'h0);

      // R7 global enable off blocks a programmed comparator
      wr(8'h08, 32'h4000_1001);
      fetch("R7 global off", 32'h0000_1000, 1'b0, 3'd0);

      // R4 enable needs key; R5 count is read-only
      wr(8'h00, 32'h0000_0001);
      rd(8'h00, v); check("R4 no key", v, 32'h60);
      wr(8'h00, 32'h0000_00F3);
      rd(8'h00, v); check("R5 count kept, R4 keyed", v, 32'h61);

      // R2 field masking
      wr(8'h14, 32'h2000_0002);
      rd(8'h14, v); check("R2 masked bits", v, 32'h0);
      wr(8'h14, 32'hFFFF_FFFF);
      rd(8'h14, v); check("R2 kept bits", v, 32'hDFFF_FFFD);

      // Program the bank
      wr(8'h0C, 32'h8000_1001);
      wr(8'h10, 32'hC000_2001);
      wr(8'h14, 32'h0000_3001);
      wr(8'h18, 32'h4000_2001);
      wr(8'h1C, 32'hDFFF_FFFD);
      rd(8'h08, v); check("R2 readback", v, 32'h4000_1001);

      for (int k = 0; k < NV; k++) begin
         fetch("R3/R6/R9 vector", VEC[k][35:4], VEC[k][3], VEC[k][2:0]);
      end

      // R10 sticky flag
      rd(8'h04, v); check("R10 flag set", v, 32'h1);
      wr(8'h04, 32'h0);
      rd(8'h04, v); check("R10 write 0 keeps", v, 32'h1);
      wr(8'h04, 32'h1);
      rd(8'h04, v); check("R10 write 1 clears", v, 32'h0);

      // R7 disabling a comparator
      wr(8'h08, 32'h4000_1000);
      fetch("R7 cmp disabled", 32'h0000_1000, 1'b0, 3'd0);
      rd(8'h04, v); check("R10 no set without req", v, 32'h0);

      // R8 back-to-back fetches give a pulse each
      @(negedge clk);
      fetch_valid = 1'b1; fetch_addr = 32'h0000_1002;
      @(negedge clk);
      fetch_addr = 32'h0000_2002;
      check("R8 first pulse", 32'(bkpt_req), 32'h1);
      check("R8 first idx", 32'(bkpt_idx), 32'd1);
      @(negedge clk);
      fetch_valid = 1'b0;
      check("R8 second pulse", 32'(bkpt_req), 32'h1);
      check("R9 second idx", 32'(bkpt_idx), 32'd2);
      @(negedge clk);
      check("R8 drops", 32'(bkpt_req), 32'h0);

      // R4 keyed disable stops requests
      wr(8'h00, 32'h0000_0002);
      rd(8'h00, v); check("R4 keyed off", v, 32'h60);
      fetch("R7 bank off", 32'h0000_2000, 1'b0, 3'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule